// File: doc/BRIEF.md
# Supply Reset and Bus-Activity Watchdog

This block supervises a processor by driving a system reset line. It puts reset on when the external supply comparator reports a low supply, and it keeps reset on for a fixed hold time after the supply recovers. The same hold applies at power-up. A watchdog also forces reset when the processor stops producing START conditions on its two-wire bus. A START is SDA falling while SCL is high. The processor chooses the watchdog interval with a two-bit code, and one value of that code turns the watchdog off.

All times are counted in millisecond ticks from a prescaler. Its length is set by a parameter that gives the number of clock cycles in one millisecond, so a bench can shorten real seconds to a few thousand cycles. A second output tells a companion bus slave to abandon the current transfer and to refuse new ones while reset is active. That slave still lets a nonvolatile write cycle that has already begun run to completion. A parameter chooses whether the reset pin is active low or active high.

Top module: `bus_supervisor`

## Requirements
- R1: While the synchronous reset `rst` is high, and right after it falls, reset is asserted and `xfer_abort` is 1. This is the power-up state.
- R2: `supply_ok` low at a clock edge asserts reset from the next edge. Reset stays asserted for every cycle in which `supply_ok` remains low.
- R3: After `supply_ok` returns high, reset stays asserted for HOLD_MS milliseconds, within one tick, and is then released. The default is 200 ms.
- R4: The watchdog restarts only on a START, which is a 1-to-0 change of SDA while SCL is 1, seen after synchronization. An SDA fall while SCL is low, SCL edges and an SDA rise while SCL is high (a STOP) do not restart it.
- R5: The `wd_sel` code sets the watchdog period: 2'b00 gives 1400 ms, 2'b01 gives 600 ms and 2'b10 gives 200 ms.
- R6: `wd_sel` = 2'b11 disables the watchdog, so reset is never caused by bus inactivity.
- R7: When the watchdog period elapses without a START, reset is asserted and then held for the same HOLD_MS as a supply reset.
- R8: The watchdog count is held at zero while reset is active. A full period is measured from the release of reset.
- R9: `xfer_abort` is 1 exactly while reset is active.
- R10: With ACTIVE_LOW = 1, `sys_reset` is 0 while reset is active. With ACTIVE_LOW = 0 it is 1 while reset is active.
- R11: SCL and SDA each pass through a two-flop synchronizer. One START gives exactly one single-cycle restart pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| supply_ok | input | 1 | Synchronous comparator result, 1 = supply above trip level |
| wd_sel | input | 2 | Watchdog period code (00 1400 ms, 01 600 ms, 10 200 ms, 11 off) |
| scl_in | input | 1 | Two-wire bus clock line, asynchronous |
| sda_in | input | 1 | Two-wire bus data line, asynchronous |
| sys_reset | output | 1 | System reset, polarity set by ACTIVE_LOW |
| xfer_abort | output | 1 | Tells the bus slave to drop current traffic and refuse new transfers |

## Verification
The hardest situation to reach is the point where the watchdog period and the hold period meet. If the count ran during the hold, a watchdog reset would fire again the moment reset released. If the count were not restarted at release, the first period would be cut short. The bench shortens a millisecond to two clock cycles and timestamps each release and assertion of reset with a free-running cycle counter. It then checks the elapsed cycles against narrow windows. Fake bus edges and a real START are placed at known offsets inside one period, and the resulting change in assertion time shows which edges restarted the count.

// File: rtl/bus_supervisor_pkg.sv
package bus_supervisor_pkg;

  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;

  // Period in milliseconds for a select code; zero means disabled.
  function automatic int unsigned wd_period_ms(wd_sel_e code, int unsigned long_ms,
                                               int unsigned mid_ms, int unsigned short_ms);
    case (code)
      WD_LONG:  return long_ms;
      WD_MID:   return mid_ms;
      WD_SHORT: return short_ms;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/ms_prescaler.sv
module ms_prescaler #(
  parameter int unsigned CLKS_PER_MS = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/start_detect.sv
module start_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic start_pulse
);
  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic                   sda_prev;
  logic                   scl_s;
  logic                   sda_s;

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign sda_s = sda_pipe[SYNC_STAGES-1];

  // Idle bus is high on both lines; reset to that so no false START.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe    <= '1;
      sda_pipe    <= '1;
      sda_prev    <= 1'b1;
      start_pulse <= 1'b0;
    end else begin
      scl_pipe    <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
      sda_pipe    <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
      sda_prev    <= sda_s;
      start_pulse <= scl_s && sda_prev && !sda_s;
    end
  end

  // R11: a START yields a single-cycle pulse
  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse);
endmodule

// File: rtl/wd_counter.sv
module wd_counter
  import bus_supervisor_pkg::*;
#(
  parameter int unsigned WD_LONG_MS  = 1400,
  parameter int unsigned WD_MID_MS   = 600,
  parameter int unsigned WD_SHORT_MS = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       kick,
  input  logic       hold_active,
  input  logic [1:0] wd_sel,
  output logic       expire
);
  localparam int unsigned MAXP = (WD_LONG_MS > WD_MID_MS) ?
      ((WD_LONG_MS > WD_SHORT_MS) ? WD_LONG_MS : WD_SHORT_MS) :
      ((WD_MID_MS > WD_SHORT_MS) ? WD_MID_MS : WD_SHORT_MS);
  localparam int unsigned CW = $clog2(MAXP + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          enabled;
  logic          at_end;

  always_comb begin
    last    = CW'(wd_period_ms(wd_sel_e'(wd_sel), WD_LONG_MS, WD_MID_MS, WD_SHORT_MS) - 1);
    enabled = (wd_sel_e'(wd_sel) != WD_OFF);
    at_end  = (cnt >= last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (hold_active || kick || !enabled) begin
        cnt <= '0;
      end else if (tick) begin
        if (at_end) begin
          cnt    <= '0;
          expire <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R8: no count accumulates while reset is held
  assert_cleared_in_hold_R8: assert property (@(posedge clk) disable iff (rst)
    hold_active |=> (cnt == '0) && !expire);
  // R6: a disabled watchdog never expires
  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (wd_sel == 2'b11) && $past(wd_sel == 2'b11) |-> !expire);
endmodule

// File: rtl/reset_hold.sv
module reset_hold #(
  parameter int unsigned HOLD_MS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic supply_ok,
  input  logic wd_expire,
  output logic active
);
  localparam int unsigned CW = $clog2(HOLD_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_MS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (!supply_ok || wd_expire) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active && tick) begin
      if (cnt == LAST) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2: low supply forces reset on the next edge
  assert_supply_low_R2: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> active);
  // R3: release happens only with a good supply and on a tick
  assert_release_ok_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> $past(supply_ok) && $past(tick));
  // R7: a watchdog expiry asserts reset
  assert_expire_resets_R7: assert property (@(posedge clk) disable iff (rst)
    wd_expire |=> active);
endmodule

// File: rtl/bus_supervisor.sv
module bus_supervisor #(
  parameter int unsigned CLKS_PER_MS = 50000,
  parameter int unsigned HOLD_MS     = 200,
  parameter int unsigned WD_LONG_MS  = 1400,
  parameter int unsigned WD_MID_MS   = 600,
  parameter int unsigned WD_SHORT_MS = 200,
  parameter bit          ACTIVE_LOW  = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok,
  input  logic [1:0] wd_sel,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sys_reset,
  output logic       xfer_abort
);
  logic tick;
  logic kick;
  logic expire;
  logic active;

  ms_prescaler #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  start_detect #(.SYNC_STAGES(2)) u_start (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .start_pulse(kick)
  );

  wd_counter #(
    .WD_LONG_MS(WD_LONG_MS), .WD_MID_MS(WD_MID_MS), .WD_SHORT_MS(WD_SHORT_MS)
  ) u_wd (
    .clk(clk), .rst(rst), .tick(tick), .kick(kick), .hold_active(active),
    .wd_sel(wd_sel), .expire(expire)
  );

  reset_hold #(.HOLD_MS(HOLD_MS)) u_hold (
    .clk(clk), .rst(rst), .tick(tick), .supply_ok(supply_ok),
    .wd_expire(expire), .active(active)
  );

  assign xfer_abort = active;

  generate
    if (ACTIVE_LOW) begin : g_low
      assign sys_reset = ~active;
    end else begin : g_high
      assign sys_reset = active;
    end
  endgenerate

  // R3: reset is held between ticks while the supply stays good
  assert_hold_steady_R3: assert property (@(posedge clk) disable iff (rst)
    active && supply_ok && !tick && !expire |=> active);
endmodule

// File: tb/bus_supervisor_tb_top.sv
module bus_supervisor_tb_top;
  localparam int CPM = 2;
  localparam int NV  = 7;
  localparam logic [1:0] VSEL [NV] = '{2'b00, 2'b01, 2'b10, 2'b10, 2'b01, 2'b11, 2'b00};
  localparam int         VGAP [NV] = '{1300, 500, 150, 250, 700, 2000, 1500};
  localparam bit         VEXP [NV] = '{0, 0, 0, 1, 1, 0, 1};

  logic clk = 0, rst = 1, supply_ok = 0, scl = 1, sda = 1;
  logic [1:0] wd_sel = 2'b11;
  logic sys_reset, xfer_abort, sys_reset_hi, xfer_abort_hi;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_supervisor #(.CLKS_PER_MS(CPM), .ACTIVE_LOW(1'b1)) dut_i (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .wd_sel(wd_sel), .scl_in(scl),
    .sda_in(sda), .sys_reset(sys_reset), .xfer_abort(xfer_abort));
  bus_supervisor #(.CLKS_PER_MS(CPM), .ACTIVE_LOW(1'b0)) dut_hi (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .wd_sel(wd_sel), .scl_in(scl),
    .sda_in(sda), .sys_reset(sys_reset_hi), .xfer_abort(xfer_abort_hi));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit rst_on();
    return sys_reset == 1'b0;
  endfunction

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_release(output int t);
    int n = 0;
    while (rst_on() && n < 5000) begin @(negedge clk); n++; end
    t = cyc;
  endtask

  task automatic wait_assert(input int limit, output int t);
    int n = 0;
    while (!rst_on() && n < limit) begin @(negedge clk); n++; end
    t = cyc;
  endtask

  task automatic power_cycle(output int t);
    supply_ok = 0; cycles(4); supply_ok = 1;
    wait_release(t);
  endtask

  task automatic bus_start();
    sda = 0; cycles(4); scl = 0; cycles(4); sda = 1; cycles(4); scl = 1; cycles(4);
  endtask

  // Edges that are not a START: SDA fall with SCL low, SCL rise, then STOP
  task automatic bus_fake();
    scl = 0; cycles(4); sda = 0; cycles(4); scl = 1; cycles(4); sda = 1; cycles(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t0, t1;
    bit seen;
    cycles(3);
    // R1: state during and right after reset
    check(rst_on(), "R1 reset asserted in rst", sys_reset, 0);
    check(xfer_abort == 1, "R1 abort in rst", xfer_abort, 1);
    @(negedge clk); rst = 0; cycles(2);
    check(rst_on() && xfer_abort, "R1 reset after rst", sys_reset, 0);

    // R3: hold time after supply comes up
    supply_ok = 1; t0 = cyc;
    cycles(390);
    check(rst_on(), "R3 still held at 195 ms", sys_reset, 0);
    check(sys_reset_hi == 1, "R10 active-high held", sys_reset_hi, 1);
    wait_release(t1);
    check((t1 - t0) >= 396 && (t1 - t0) <= 410, "R3 hold length cycles", t1 - t0, 400);
    check(xfer_abort == 0, "R9 abort clear after release", xfer_abort, 0);
    check(sys_reset_hi == 0, "R10 active-high released", sys_reset_hi, 0);

    // R2: brownout asserts at once and lasts
    cycles(20);
    supply_ok = 0; cycles(2);
    check(rst_on(), "R2 asserted on low supply", sys_reset, 0);
    check(xfer_abort == 1, "R9 abort on low supply", xfer_abort, 1);
    cycles(900);
    check(rst_on(), "R2 held while supply low", sys_reset, 0);
    supply_ok = 1;
    wait_release(t0);

    // R5 R7 R8: 200 ms period counted from release, then a full hold
    wd_sel = 2'b10;
    power_cycle(t0);
    wait_assert(3000, t1);
    check((t1 - t0) >= 396 && (t1 - t0) <= 412, "R8 R5 expiry 200 ms from release",
          t1 - t0, 400);
    wait_release(t0);
    check((t0 - t1) >= 394 && (t0 - t1) <= 408, "R7 watchdog hold length", t0 - t1, 400);

    // R4: non-START edges do not restart
    power_cycle(t0);
    cycles(300); bus_fake();
    wait_assert(3000, t1);
    check((t1 - t0) >= 396 && (t1 - t0) <= 412, "R4 fake edges ignored", t1 - t0, 400);

    // R4 R11: one START restarts once
    power_cycle(t0);
    cycles(300); bus_start();
    wait_assert(3000, t1);
    check((t1 - t0) >= 696 && (t1 - t0) <= 716, "R4 R11 START restarts period",
          t1 - t0, 704);

    // R6: disabled watchdog stays quiet
    wd_sel = 2'b11;
    power_cycle(t0);
    cycles(4000);
    check(!rst_on(), "R6 disabled no reset", sys_reset, 1);

    // R5 R6: period table walk with kicks at fixed gaps
    for (int v = 0; v < NV; v++) begin
      wd_sel = VSEL[v];
      power_cycle(t0);
      seen = 0;
      for (int k = 0; k < 3; k++) begin
        for (int c = 0; c < VGAP[v] * CPM; c++) begin
          @(negedge clk);
          if (rst_on()) seen = 1;
        end
        bus_start();
      end
      check(seen == VEXP[v], $sformatf("R5 vector %0d sel=%0d gap=%0d", v, VSEL[v], VGAP[v]),
            seen, VEXP[v]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule